// File: doc/BRIEF.md
# Binary/Decimal Add-Subtract-Compare Unit

An 8-bit arithmetic unit for an 8-bit accumulator-style processor core. It takes a register value, an operand, a carry input and a decimal-mode flag. It produces an add-with-carry, a subtract-with-borrow or a compare result, together with the negative, zero, carry and overflow flags. In decimal mode the operands are treated as packed BCD, and nibble and byte corrections are applied to the sum or difference.

A build-time parameter picks one of two flag conventions. In the early convention, the decimal-mode N and Z flags follow intermediate or plain binary values. In the later convention, N and Z follow the corrected result, and the unit raises an extra-cycle indication so the sequencer can insert one more clock for a decimal add or subtract. The arithmetic is combinational and every output is registered, so a result appears one clock after the input is accepted. Operand fetch and instruction sequencing belong to the surrounding core.

Top module: `bcd_alu_top`

## Requirements
- R1: Binary add (op_sel 2'b00, dec_mode 0): result = (reg_a + operand + carry_in) mod 256. C = 1 when the 9-bit sum exceeds 255. V = 1 when reg_a and operand have equal bit 7 and the sum's bit 7 differs from operand's. N = result bit 7, Z = (result == 0).
- R2: Binary subtract (op_sel 2'b01, dec_mode 0): result = (reg_a − operand − (1 − carry_in)) mod 256. C = 1 when no borrow occurs. V = 1 when reg_a and operand differ in bit 7 and reg_a and the result also differ in bit 7. N and Z come from the result.
- R3: Decimal add: the low-nibble sum with carry, if 10 or more, is replaced by ((low+6) AND 0x0F)+0x10. The high nibbles are then added to it. V is taken from that uncorrected sum. 0x60 is added when the sum is at least 0xA0. C = 1 when the corrected value is at least 0x100, and result is its low byte.
- R4: With the early convention (CMOS_FLAGS=0), decimal-add N is bit 7 of the uncorrected high sum, and Z is set when the plain binary sum byte is zero.
- R5: Early-convention decimal subtract: a negative low-nibble difference becomes ((low−6) AND 0x0F)−0x10. It is added to the high-nibble difference, and 0x60 is taken away when the total is negative. N, Z, V and C all equal those of the binary subtract.
- R6: Later-convention decimal subtract: the full difference reg_a − operand − borrow has 0x60 taken away when it is negative, and then 6 when the low-nibble difference was negative. V and C follow the binary subtract. N and Z follow the corrected result. The later-convention decimal add also takes N and Z from its corrected result.
- R7: Compare (op_sel 2'b10, and 2'b11 acts the same): C = (reg_a >= operand). N and Z come from the byte (reg_a − operand). The outcome does not depend on dec_mode.
- R8: Compare leaves the register and V untouched: result = reg_a and flag_v = v_in.
- R9: extra_cycle = 1 exactly for a decimal add or subtract when CMOS_FLAGS=1. It is 0 for binary operations, for compare, and always with CMOS_FLAGS=0.
- R10: Each accepted input (in_valid high at a rising edge) shows up on the outputs with out_valid high after exactly that one edge. out_valid is low in cycles with no input.
- R11: While rst_n is low at a rising edge, out_valid, result and all flags become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op_sel | input | 2 | 00 add, 01 subtract, 10/11 compare |
| reg_a | input | 8 | Accumulator or index register value |
| operand | input | 8 | Memory or immediate operand |
| carry_in | input | 1 | Current carry flag |
| dec_mode | input | 1 | Current decimal flag |
| v_in | input | 1 | Current overflow flag, passed through by compare |
| out_valid | output | 1 | Registered outputs hold a new result |
| result | output | 8 | Result byte |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| extra_cycle | output | 1 | Decimal operation needs one more clock (later convention) |

## Verification
Both variants are instantiated together and receive the same stream. Any disagreement between them in decimal mode isolates the N/Z source, the subtract correction order and the extra-cycle flag. A strided sweep of register and operand values, covering both carry inputs, both modes and all three operations, exercises nibble sums above and below 10, byte sums on both sides of 0xA0 and 0x100, and negative low and high differences. Directed vectors hit specific cases: 0x99+0x01, 0x00−0x01 in decimal, the signed-overflow edges 0x7F+1 and 0x80−1, invalid BCD digits, and compare with dec_mode and v_in set.

// File: rtl/bcd_alu_pkg.sv
// Shared types for the add/subtract/compare unit.
// Assumes an 8-bit data path; the nibble width follows from it.
package bcd_alu_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;

    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_SUB     = 2'b01,
        OP_CMP     = 2'b10,
        OP_CMP_ALT = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          n;
        logic          z;
        logic          c;
        logic          v;
    } alu_out_t;
endpackage

// File: rtl/alu_bin_core.sv
// Binary arithmetic: add-with-carry, subtract-with-borrow and compare.
// Purely combinational. The binary add and subtract outputs also feed
// the decimal paths, which borrow flags from them.
module alu_bin_core
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          vin,
    output alu_out_t      add_o,
    output alu_out_t      sub_o,
    output alu_out_t      cmp_o
);
    logic [DW:0] sum_w;
    logic [DW:0] dif_w;
    logic [DW:0] cmp_w;

    // 9-bit sum and differences; bit DW is carry-out or borrow
    always_comb begin
        sum_w = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        dif_w = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, ~cin};
        cmp_w = {1'b0, a} - {1'b0, b};
    end

    // Flag formation for the three binary operations
    always_comb begin
        add_o.res = sum_w[DW-1:0];
        add_o.n   = sum_w[DW-1];
        add_o.z   = (sum_w[DW-1:0] == '0);
        add_o.c   = sum_w[DW];
        add_o.v   = ~(a[DW-1] ^ b[DW-1]) & (b[DW-1] ^ sum_w[DW-1]);

        sub_o.res = dif_w[DW-1:0];
        sub_o.n   = dif_w[DW-1];
        sub_o.z   = (dif_w[DW-1:0] == '0);
        sub_o.c   = ~dif_w[DW];
        sub_o.v   = (a[DW-1] ^ dif_w[DW-1]) & (a[DW-1] ^ b[DW-1]);

        cmp_o.res = a;
        cmp_o.n   = cmp_w[DW-1];
        cmp_o.z   = (cmp_w[DW-1:0] == '0);
        cmp_o.c   = ~cmp_w[DW];
        cmp_o.v   = vin;
    end
endmodule

// File: rtl/alu_dec_add.sv
// Packed-BCD add. Applies the low-nibble correction, then the high
// correction. CMOS_FLAGS picks the source of N and Z: intermediate/binary
// (0) or the corrected result (1). bin_zero is the binary-sum zero flag.
module alu_dec_add
    import bcd_alu_pkg::*;
#(
    parameter bit CMOS_FLAGS = 1'b0
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          bin_zero,
    output alu_out_t      dec_o
);
    localparam logic [NW:0]   LO_LIMIT = (NW+1)'(10);
    localparam logic [NW-1:0] LO_FIX   = NW'(6);
    localparam logic [DW:0]   HI_LIMIT = (DW+1)'(8'hA0);
    localparam logic [DW+1:0] HI_FIX   = (DW+2)'(8'h60);

    logic [NW:0]   lo_raw;
    logic [NW:0]   lo_adj;
    logic [DW:0]   hi_raw;
    logic [DW+1:0] fixed;

    // Nibble sum, its correction, then high sum and its correction
    always_comb begin
        lo_raw = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        lo_adj = (lo_raw >= LO_LIMIT) ? {1'b1, lo_raw[NW-1:0] + LO_FIX} : lo_raw;
        hi_raw = {1'b0, a[DW-1:NW], {NW{1'b0}}} + {1'b0, b[DW-1:NW], {NW{1'b0}}}
               + {{(DW-NW){1'b0}}, lo_adj};
        fixed  = (hi_raw >= HI_LIMIT) ? ({1'b0, hi_raw} + HI_FIX) : {1'b0, hi_raw};
    end

    // Result, carry and overflow are common to both conventions
    always_comb begin
        dec_o.res = fixed[DW-1:0];
        dec_o.c   = |fixed[DW+1:DW];
        dec_o.v   = ~(a[DW-1] ^ b[DW-1]) & (b[DW-1] ^ hi_raw[DW-1]);
        dec_o.n   = 1'b0;
        dec_o.z   = 1'b0;
        if (CMOS_FLAGS) begin
            dec_o.n = fixed[DW-1];
            dec_o.z = (fixed[DW-1:0] == '0);
        end else begin
            dec_o.n = hi_raw[DW-1];
            dec_o.z = bin_zero;
        end
    end
endmodule

// File: rtl/alu_dec_sub.sv
// Packed-BCD subtract. CMOS_FLAGS selects one of two correction orders:
// nibble-then-byte with all flags binary (0), or byte-then-nibble on the
// full difference with N/Z from the result (1). bin_o is the binary subtract.
module alu_dec_sub
    import bcd_alu_pkg::*;
#(
    parameter bit CMOS_FLAGS = 1'b0
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  alu_out_t      bin_o,
    output alu_out_t      dec_o
);
    localparam int            XW     = DW + 2;
    localparam logic [NW-1:0] LO_FIX = NW'(6);
    localparam logic [XW-1:0] HI_FIX = XW'(8'h60);
    localparam logic [XW-1:0] LO_SUB = XW'(6);

    logic [NW+1:0] lo_raw;
    logic          lo_neg;
    logic [XW-1:0] fixed;

    // Signed low-nibble difference, shared by both orders
    always_comb begin
        lo_raw = {2'b00, a[NW-1:0]} - {2'b00, b[NW-1:0]} - {{(NW+1){1'b0}}, ~cin};
        lo_neg = lo_raw[NW+1];
    end

    if (CMOS_FLAGS) begin : g_late
        logic [XW-1:0] full;
        logic [XW-1:0] step1;
        // Byte correction on the full difference, then nibble correction
        always_comb begin
            full  = {2'b00, a} - {2'b00, b} - {{(XW-1){1'b0}}, ~cin};
            step1 = full[XW-1] ? (full - HI_FIX) : full;
            fixed = lo_neg ? (step1 - LO_SUB) : step1;
        end
        // N and Z follow the corrected byte
        always_comb begin
            dec_o.res = fixed[DW-1:0];
            dec_o.n   = fixed[DW-1];
            dec_o.z   = (fixed[DW-1:0] == '0);
            dec_o.c   = bin_o.c;
            dec_o.v   = bin_o.v;
        end
    end else begin : g_early
        logic [XW-1:0] lo_adj;
        logic [XW-1:0] hi_raw;
        // Nibble correction first, merged into the high difference
        always_comb begin
            lo_adj = lo_neg ? {{(XW-NW){1'b1}}, lo_raw[NW-1:0] - LO_FIX}
                            : {{(XW-NW){1'b0}}, lo_raw[NW-1:0]};
            hi_raw = {2'b00, a[DW-1:NW], {NW{1'b0}}} - {2'b00, b[DW-1:NW], {NW{1'b0}}}
                   + lo_adj;
            fixed  = hi_raw[XW-1] ? (hi_raw - HI_FIX) : hi_raw;
        end
        // All flags come from the binary difference
        always_comb begin
            dec_o.res = fixed[DW-1:0];
            dec_o.n   = bin_o.n;
            dec_o.z   = bin_o.z;
            dec_o.c   = bin_o.c;
            dec_o.v   = bin_o.v;
        end
    end
endmodule

// File: rtl/bcd_alu_top.sv
// Add/subtract/compare unit with binary and packed-BCD modes. Selects among
// the binary, decimal-add and decimal-subtract paths and registers the
// outcome. Latency one clock; assumes inputs are stable around the edge.
module bcd_alu_top
    import bcd_alu_pkg::*;
#(
    parameter bit CMOS_FLAGS = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    op_sel,
    input  logic [DW-1:0] reg_a,
    input  logic [DW-1:0] operand,
    input  logic          carry_in,
    input  logic          dec_mode,
    input  logic          v_in,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_c,
    output logic          flag_v,
    output logic          extra_cycle
);
    alu_op_e  op;
    alu_out_t add_b, sub_b, cmp_b, add_d, sub_d, sel;
    logic     xc_d;

    alu_bin_core u_bin (
        .a(reg_a), .b(operand), .cin(carry_in), .vin(v_in),
        .add_o(add_b), .sub_o(sub_b), .cmp_o(cmp_b)
    );

    alu_dec_add #(.CMOS_FLAGS(CMOS_FLAGS)) u_dadd (
        .a(reg_a), .b(operand), .cin(carry_in),
        .bin_zero(add_b.z), .dec_o(add_d)
    );

    alu_dec_sub #(.CMOS_FLAGS(CMOS_FLAGS)) u_dsub (
        .a(reg_a), .b(operand), .cin(carry_in),
        .bin_o(sub_b), .dec_o(sub_d)
    );

    // Operation decode and path selection
    always_comb begin
        op   = alu_op_e'(op_sel);
        xc_d = 1'b0;
        unique case (op)
            OP_ADD: begin
                sel  = dec_mode ? add_d : add_b;
                xc_d = CMOS_FLAGS & dec_mode;
            end
            OP_SUB: begin
                sel  = dec_mode ? sub_d : sub_b;
                xc_d = CMOS_FLAGS & dec_mode;
            end
            default: sel = cmp_b;
        endcase
    end

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            result      <= '0;
            flag_n      <= 1'b0;
            flag_z      <= 1'b0;
            flag_c      <= 1'b0;
            flag_v      <= 1'b0;
            extra_cycle <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result      <= sel.res;
                flag_n      <= sel.n;
                flag_z      <= sel.z;
                flag_c      <= sel.c;
                flag_v      <= sel.v;
                extra_cycle <= xc_d;
            end
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                              // R10
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                            // R10
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[1]) |=> (result == $past(reg_a) && flag_v == $past(v_in))); // R8
    AST_CMP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[1]) |=> (flag_c == ($past(reg_a) >= $past(operand))));    // R7
    AST_BIN_NO_XC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!dec_mode || op_sel[1])) |=> !extra_cycle);             // R9
    AST_BIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec_mode && !op_sel[1]) |=> (flag_z == (result == '0)));// R1
    AST_BIN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec_mode && !op_sel[1]) |=> (flag_n == result[DW-1]));  // R2
endmodule

// File: tb/tb_bcd_alu_top.sv
`timescale 1ns/1ps
module tb_bcd_alu_top;
    typedef struct packed {
        logic [7:0] res;
        logic n, z, c, v, x;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] op_sel = 2'b00;
    logic [7:0] reg_a = 8'h00, operand = 8'h00;
    logic carry_in = 1'b0, dec_mode = 1'b0, v_in = 1'b0;

    logic ov0, n0, z0, c0, v0, x0;
    logic ov1, n1, z1, c1, v1, x1;
    logic [7:0] r0, r1;

    int vectors = 0;
    int fails = 0;
    exp_t q0[$];
    exp_t q1[$];
    logic [1:0] opq0[$];
    logic [1:0] opq1[$];
    logic decq0[$];
    logic decq1[$];

    always #5 clk = ~clk;

    bcd_alu_top #(.CMOS_FLAGS(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .reg_a(reg_a), .operand(operand), .carry_in(carry_in),
        .dec_mode(dec_mode), .v_in(v_in), .out_valid(ov0), .result(r0),
        .flag_n(n0), .flag_z(z0), .flag_c(c0), .flag_v(v0), .extra_cycle(x0));

    bcd_alu_top #(.CMOS_FLAGS(1'b1)) dut_cmos (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .reg_a(reg_a), .operand(operand), .carry_in(carry_in),
        .dec_mode(dec_mode), .v_in(v_in), .out_valid(ov1), .result(r1),
        .flag_n(n1), .flag_z(z1), .flag_c(c1), .flag_v(v1), .extra_cycle(x1));

    // Behavioural model written from the requirements
    function automatic exp_t model(int op, int a, int d, int c, int dec, int vin, int cm);
        exp_t e;
        int bin, al, s;
        e = '0;
        if (op >= 2) begin                       // R7 R8
            bin = a - d;
            e.res = 8'(a);
            e.c = (a >= d);
            e.n = ((bin & 128) != 0);
            e.z = ((bin & 255) == 0);
            e.v = vin[0];
        end else if (op == 0) begin
            bin = a + d + c;
            if (dec == 0) begin                  // R1
                e.res = 8'(bin);
                e.c = (bin > 255);
                e.v = (((a ^ d) & 128) == 0) && (((d ^ bin) & 128) != 0);
                e.n = e.res[7];
                e.z = (e.res == 0);
            end else begin                       // R3 R4
                al = (a & 15) + (d & 15) + c;
                if (al >= 10) al = ((al + 6) & 15) + 16;
                s = (a & 240) + (d & 240) + al;
                e.v = (((a ^ d) & 128) == 0) && (((d ^ s) & 128) != 0);
                e.n = ((s & 128) != 0);
                if (s >= 160) s = s + 96;
                e.c = (s >= 256);
                e.res = 8'(s);
                if (cm != 0) begin
                    e.n = e.res[7];
                    e.z = (e.res == 0);
                    e.x = 1'b1;
                end else begin
                    e.z = ((bin & 255) == 0);
                end
            end
        end else begin
            bin = a - d - (1 - c);
            e.c = (bin >= 0);
            e.v = (((a ^ bin) & 128) != 0) && (((a ^ d) & 128) != 0);
            e.n = ((bin & 128) != 0);
            e.z = ((bin & 255) == 0);
            e.res = 8'(bin);
            if (dec != 0) begin
                al = (a & 15) - (d & 15) - (1 - c);
                if (cm == 0) begin               // R5
                    if (al < 0) al = ((al - 6) & 15) - 16;
                    s = (a & 240) - (d & 240) + al;
                    if (s < 0) s = s - 96;
                    e.res = 8'(s);
                end else begin                   // R6
                    s = bin;
                    if (s < 0) s = s - 96;
                    if (al < 0) s = s - 6;
                    e.res = 8'(s);
                    e.n = e.res[7];
                    e.z = (e.res == 0);
                    e.x = 1'b1;
                end
            end
        end
        return e;
    endfunction

    function automatic string tag_of(logic [1:0] op, logic dec, int cm);
        if (op[1]) return "R7 R8";
        if (!dec) return (op == 2'b00) ? "R1" : "R2";
        if (op == 2'b00) return (cm != 0) ? "R3 R6" : "R3 R4";
        return (cm != 0) ? "R6" : "R5";
    endfunction

    task automatic compare(string who, exp_t got, exp_t e, logic [1:0] op, logic dec, int cm);
        string t;
        vectors++;
        t = tag_of(op, dec, cm);
        if (got.x != e.x) t = "R9";
        if (got != e) begin
            fails++;
            $display("FAIL %s %s: got res=%02h nzcvx=%b%b%b%b%b expected res=%02h nzcvx=%b%b%b%b%b",
                     t, who, got.res, got.n, got.z, got.c, got.v, got.x,
                     e.res, e.n, e.z, e.c, e.v, e.x);
        end
    endtask

    // Driver: apply one vector and queue the expected outcome for both variants
    task automatic drive(logic [1:0] op, logic [7:0] a, logic [7:0] d, logic c, logic dec, logic vin);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; reg_a = a; operand = d;
        carry_in = c; dec_mode = dec; v_in = vin;
        q0.push_back(model(int'(op), int'(a), int'(d), int'(c), int'(dec), int'(vin), 0));
        q1.push_back(model(int'(op), int'(a), int'(d), int'(c), int'(dec), int'(vin), 1));
        opq0.push_back(op); opq1.push_back(op);
        decq0.push_back(dec); decq1.push_back(dec);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor for the early-convention instance (R10 ordering)
    always @(posedge clk) begin
        #1;
        if (rst_n && ov0) begin
            if (q0.size() == 0) begin
                fails++; vectors++;
                $display("FAIL R10 dut: out_valid=1 expected 0");
            end else begin
                compare("dut", {r0, n0, z0, c0, v0, x0}, q0.pop_front(),
                        opq0.pop_front(), decq0.pop_front(), 0);
            end
        end
    end

    // Monitor for the later-convention instance
    always @(posedge clk) begin
        #1;
        if (rst_n && ov1) begin
            if (q1.size() == 0) begin
                fails++; vectors++;
                $display("FAIL R10 dut_cmos: out_valid=1 expected 0");
            end else begin
                compare("dut_cmos", {r1, n1, z1, c1, v1, x1}, q1.pop_front(),
                        opq1.pop_front(), decq1.pop_front(), 1);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state of both instances
        vectors++;
        if ({ov0, r0, n0, z0, c0, v0, x0} != '0) begin
            fails++;
            $display("FAIL R11 dut: got %h expected 0", {ov0, r0, n0, z0, c0, v0, x0});
        end
        vectors++;
        if ({ov1, r1, n1, z1, c1, v1, x1} != '0) begin
            fails++;
            $display("FAIL R11 dut_cmos: got %h expected 0", {ov1, r1, n1, z1, c1, v1, x1});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        drive(2'b00, 8'h99, 8'h01, 1'b0, 1'b1, 1'b0);   // R3 wrap to 00 with carry
        drive(2'b00, 8'h58, 8'h46, 1'b1, 1'b1, 1'b0);   // R3 105 decimal
        drive(2'b00, 8'h0F, 8'h0F, 1'b0, 1'b1, 1'b0);   // R4 invalid digits
        drive(2'b00, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);   // R1 signed overflow
        drive(2'b00, 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0);   // R1 carry, zero
        drive(2'b01, 8'h80, 8'h01, 1'b1, 1'b0, 1'b0);   // R2 signed overflow
        drive(2'b01, 8'h00, 8'h01, 1'b1, 1'b1, 1'b0);   // R5 R6 decimal borrow
        drive(2'b01, 8'h12, 8'h21, 1'b0, 1'b1, 1'b0);   // R5 R6
        drive(2'b01, 8'h0A, 8'h0F, 1'b1, 1'b1, 1'b0);   // R6 order difference
        idle(2);                                        // R10 gaps
        drive(2'b10, 8'h40, 8'h40, 1'b0, 1'b1, 1'b1);   // R7 R8 equal, dec set
        drive(2'b11, 8'h10, 8'h20, 1'b1, 1'b0, 1'b0);   // R7 alternate code
        drive(2'b10, 8'hF0, 8'h05, 1'b0, 1'b1, 1'b1);   // R8 V kept

        // Strided sweep: all ops, both modes, both carries
        for (int a = 0; a < 256; a += 3) begin
            for (int d = 0; d < 256; d += 5) begin
                for (int k = 0; k < 12; k++) begin
                    drive(2'(k % 3), 8'(a), 8'(d), 1'(k / 6), 1'((k / 3) % 2), 1'((a ^ d) & 1));
                end
            end
            idle(1);
        end

        idle(4);
        vectors++;
        if (q0.size() != 0 || q1.size() != 0) begin
            fails++;
            $display("FAIL R10: %0d/%0d results missing, expected 0", q0.size(), q1.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule